// File: doc/BRIEF.md
# Integer ALU with shifter

This block is the 32-bit integer execution unit of a small load/store processor. Each cycle the issue stage hands it an already split instruction: the primary opcode, the function code, two register operands, the 16-bit immediate and the 5-bit shift count, qualified by a valid strobe. The unit works out which operand B to use (the register value, the sign-extended immediate or the zero-extended immediate). It computes the arithmetic, logic, compare, upper-immediate or shift result, and registers that result together with a signed-overflow flag and an illegal-operation flag.

The output register acts as the timing stage. A result appears one clock after its operation is presented. When no operation is presented, the output register keeps its contents. The reset input clears asynchronously, and an internal two-flop synchronizer releases it on a clock edge. The overflow flag is only a report: the wrapped sum is still returned, and acting on the flag is left to the surrounding pipeline.

Top module: `ialu_core`

## Requirements
- R1: While reset is held and until the first accepted operation, res_valid, result, ovf and illegal are all zero.
- R2: An operation presented with op_valid high in one cycle appears on the outputs after the next rising edge, with res_valid high. In a cycle where op_valid is low, res_valid drops and result, ovf and illegal keep their previous values, whatever the other inputs do.
- R3: With opcode 0, function codes (octal) 40 ADD, 41 ADDU, 42 SUB and 43 SUBU return src_a plus or minus src_b, modulo 2^32. ovf is raised only for ADD, SUB and ADDI (opcode octal 10) on two's-complement signed overflow. ADDU, SUBU and ADDIU (opcode octal 11) never raise it.
- R4: With opcode 0, function codes (octal) 44, 45, 46 and 47 return the bitwise AND, OR, XOR and NOR of src_a and src_b. NOR is the inverse of the OR.
- R5: The immediate forms use the immediate as operand B. ADDI 10, ADDIU 11, SLTI 12 and SLTIU 13 (octal opcodes) sign-extend it. ANDI 14, ORI 15 and XORI 16 zero-extend it.
- R6: Set-less-than returns exactly 1 when src_a is below operand B and 0 otherwise. SLT (funct 52) and SLTI compare as signed values. SLTU (funct 53) and SLTIU compare as unsigned values.
- R7: LUI (opcode octal 17) returns the immediate in bits 31:16 with bits 15:0 cleared, ignoring both register operands.
- R8: With opcode 0, function code 00 shifts src_b left, 02 shifts it right filling with zeros, and 03 shifts it right filling with copies of bit 31. The distance is shamt, from 0 to 31.
- R9: Any other opcode, or any other function code under opcode 0, returns result 0 with ovf low and illegal high. Every defined operation returns illegal low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present this cycle |
| opcode | input | 6 | Primary opcode |
| funct | input | 6 | Function code, used when opcode is 0 |
| src_a | input | 32 | First register operand |
| src_b | input | 32 | Second register operand, also the shift source |
| imm16 | input | 16 | Instruction immediate |
| shamt | input | 5 | Shift distance |
| res_valid | output | 1 | Registered result is from an operation of the previous cycle |
| result | output | 32 | Registered result |
| ovf | output | 1 | Signed overflow of ADD, SUB or ADDI |
| illegal | output | 1 | Opcode/function pair was not defined |

## Verification
The properties assume that all inputs are known, not X, at every rising edge after the internal reset has been released. They also assume that op_valid stays low until that release. The bench holds op_valid low and all data inputs at zero throughout reset, and it waits several cycles after reset is released before issuing anything. It changes inputs only on falling edges, so each value is settled long before the edge that captures it. Idle cycles carry random data on the operand, opcode and immediate inputs so that the hold behaviour is tested against inputs that actually change.

// File: rtl/ialu_pkg.sv
package ialu_pkg;

  localparam int OPC_W = 6;
  localparam int FN_W  = 6;

  localparam logic [OPC_W-1:0] OPC_REG   = 6'o00;
  localparam logic [OPC_W-1:0] OPC_ADDI  = 6'o10;
  localparam logic [OPC_W-1:0] OPC_ADDIU = 6'o11;
  localparam logic [OPC_W-1:0] OPC_SLTI  = 6'o12;
  localparam logic [OPC_W-1:0] OPC_SLTIU = 6'o13;
  localparam logic [OPC_W-1:0] OPC_ANDI  = 6'o14;
  localparam logic [OPC_W-1:0] OPC_ORI   = 6'o15;
  localparam logic [OPC_W-1:0] OPC_XORI  = 6'o16;
  localparam logic [OPC_W-1:0] OPC_LUI   = 6'o17;

  localparam logic [FN_W-1:0] FN_SLL  = 6'o00;
  localparam logic [FN_W-1:0] FN_SRL  = 6'o02;
  localparam logic [FN_W-1:0] FN_SRA  = 6'o03;
  localparam logic [FN_W-1:0] FN_ADD  = 6'o40;
  localparam logic [FN_W-1:0] FN_ADDU = 6'o41;
  localparam logic [FN_W-1:0] FN_SUB  = 6'o42;
  localparam logic [FN_W-1:0] FN_SUBU = 6'o43;
  localparam logic [FN_W-1:0] FN_AND  = 6'o44;
  localparam logic [FN_W-1:0] FN_OR   = 6'o45;
  localparam logic [FN_W-1:0] FN_XOR  = 6'o46;
  localparam logic [FN_W-1:0] FN_NOR  = 6'o47;
  localparam logic [FN_W-1:0] FN_SLT  = 6'o52;
  localparam logic [FN_W-1:0] FN_SLTU = 6'o53;

  // internal operation class after decode
  typedef enum logic [3:0] {
    XOP_ADD, XOP_SUB, XOP_AND, XOP_OR, XOP_XOR, XOP_NOR,
    XOP_LTS, XOP_LTU, XOP_UPPER, XOP_SHL, XOP_SHR, XOP_SAR, XOP_NONE
  } xop_e;

  // operand B source
  typedef enum logic [1:0] {
    BSRC_REG, BSRC_SEXT, BSRC_ZEXT
  } bsrc_e;

  typedef struct packed {
    xop_e  xop;
    bsrc_e bsrc;
    logic  trap_ovf;
    logic  bad;
  } ctl_s;

endpackage

// File: rtl/ialu_decode.sv
module ialu_decode
  import ialu_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output ctl_s             ctl
);

  always_comb begin
    ctl.xop      = XOP_NONE;
    ctl.bsrc     = BSRC_REG;
    ctl.trap_ovf = 1'b0;
    ctl.bad      = 1'b0;
    case (opcode)
      OPC_REG: begin
        case (funct)
          FN_SLL:  ctl.xop = XOP_SHL;
          FN_SRL:  ctl.xop = XOP_SHR;
          FN_SRA:  ctl.xop = XOP_SAR;
          FN_ADD:  begin ctl.xop = XOP_ADD; ctl.trap_ovf = 1'b1; end
          FN_ADDU: ctl.xop = XOP_ADD;
          FN_SUB:  begin ctl.xop = XOP_SUB; ctl.trap_ovf = 1'b1; end
          FN_SUBU: ctl.xop = XOP_SUB;
          FN_AND:  ctl.xop = XOP_AND;
          FN_OR:   ctl.xop = XOP_OR;
          FN_XOR:  ctl.xop = XOP_XOR;
          FN_NOR:  ctl.xop = XOP_NOR;
          FN_SLT:  ctl.xop = XOP_LTS;
          FN_SLTU: ctl.xop = XOP_LTU;
          default: ctl.bad = 1'b1;
        endcase
      end
      OPC_ADDI:  begin ctl.xop = XOP_ADD; ctl.bsrc = BSRC_SEXT; ctl.trap_ovf = 1'b1; end
      OPC_ADDIU: begin ctl.xop = XOP_ADD; ctl.bsrc = BSRC_SEXT; end
      OPC_SLTI:  begin ctl.xop = XOP_LTS; ctl.bsrc = BSRC_SEXT; end
      OPC_SLTIU: begin ctl.xop = XOP_LTU; ctl.bsrc = BSRC_SEXT; end
      OPC_ANDI:  begin ctl.xop = XOP_AND; ctl.bsrc = BSRC_ZEXT; end
      OPC_ORI:   begin ctl.xop = XOP_OR;  ctl.bsrc = BSRC_ZEXT; end
      OPC_XORI:  begin ctl.xop = XOP_XOR; ctl.bsrc = BSRC_ZEXT; end
      OPC_LUI:   ctl.xop = XOP_UPPER;
      default:   ctl.bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/ialu_addsub.sv
module ialu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf_s,
  output logic         lt_s,
  output logic         lt_u
);

  logic [W-1:0] b_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff = sub ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    sum   = wide[W-1:0];
    ovf_s = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    // valid when sub is set: borrow means unsigned below
    lt_s  = sum[W-1] ^ ovf_s;
    lt_u  = ~wide[W];
  end

endmodule

// File: rtl/ialu_shifter.sv
module ialu_shifter #(
  parameter int W = 32,
  localparam int SH_W = $clog2(W)
) (
  input  logic [W-1:0]    din,
  input  logic [SH_W-1:0] amt,
  input  logic            left,
  input  logic            arith,
  output logic [W-1:0]    dout
);

  logic            fill;
  logic [W-1:0]    stage [SH_W+1];

  assign fill     = arith & din[W-1];
  assign stage[0] = din;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    localparam int K = 1 << s;
    logic [W-1:0] moved;
    assign moved = left ? {stage[s][W-1-K:0], {K{1'b0}}}
                        : {{K{fill}}, stage[s][W-1:K]};
    assign stage[s+1] = amt[s] ? moved : stage[s];
  end

  assign dout = stage[SH_W];

endmodule

// File: rtl/ialu_core.sv
module ialu_core
  import ialu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  localparam int SH_W = $clog2(XLEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [FN_W-1:0]   funct,
  input  logic [XLEN-1:0]   src_a,
  input  logic [XLEN-1:0]   src_b,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [SH_W-1:0]   shamt,
  output logic              res_valid,
  output logic [XLEN-1:0]   result,
  output logic              ovf,
  output logic              illegal
);

  localparam int PAD_W = XLEN - IMM_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  ctl_s ctl;
  ialu_decode u_dec (.opcode(opcode), .funct(funct), .ctl(ctl));

  logic [XLEN-1:0] opb;
  always_comb begin
    case (ctl.bsrc)
      BSRC_SEXT: opb = {{PAD_W{imm16[IMM_W-1]}}, imm16};
      BSRC_ZEXT: opb = {{PAD_W{1'b0}}, imm16};
      default:   opb = src_b;
    endcase
  end

  logic            do_sub;
  logic [XLEN-1:0] sum;
  logic            ovf_s, lt_s, lt_u;

  assign do_sub = (ctl.xop == XOP_SUB) || (ctl.xop == XOP_LTS) || (ctl.xop == XOP_LTU);

  ialu_addsub #(.W(XLEN)) u_add (
    .a(src_a), .b(opb), .sub(do_sub),
    .sum(sum), .ovf_s(ovf_s), .lt_s(lt_s), .lt_u(lt_u)
  );

  logic [XLEN-1:0] sh_out;
  ialu_shifter #(.W(XLEN)) u_shf (
    .din(src_b), .amt(shamt),
    .left(ctl.xop == XOP_SHL), .arith(ctl.xop == XOP_SAR),
    .dout(sh_out)
  );

  // next-state
  logic [XLEN-1:0] res_nxt;
  logic            ovf_nxt, ill_nxt;

  always_comb begin
    case (ctl.xop)
      XOP_ADD, XOP_SUB:        res_nxt = sum;
      XOP_AND:                 res_nxt = src_a & opb;
      XOP_OR:                  res_nxt = src_a | opb;
      XOP_XOR:                 res_nxt = src_a ^ opb;
      XOP_NOR:                 res_nxt = ~(src_a | opb);
      XOP_LTS:                 res_nxt = {{(XLEN-1){1'b0}}, lt_s};
      XOP_LTU:                 res_nxt = {{(XLEN-1){1'b0}}, lt_u};
      XOP_UPPER:               res_nxt = {imm16, {PAD_W{1'b0}}};
      XOP_SHL, XOP_SHR, XOP_SAR: res_nxt = sh_out;
      default:                 res_nxt = '0;
    endcase
    ovf_nxt = ctl.trap_ovf & ovf_s;
    ill_nxt = ctl.bad;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_valid <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        result  <= res_nxt;
        ovf     <= ovf_nxt;
        illegal <= ill_nxt;
      end
    end
  end

endmodule

// File: rtl/ialu_core_chk.sv
module ialu_core_chk
  import ialu_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16,
  localparam int SH_W = $clog2(XLEN)
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             op_valid,
  input logic [OPC_W-1:0] opcode,
  input logic [FN_W-1:0]  funct,
  input logic [XLEN-1:0]  src_a,
  input logic [XLEN-1:0]  src_b,
  input logic [IMM_W-1:0] imm16,
  input logic [SH_W-1:0]  shamt,
  input logic             res_valid,
  input logic [XLEN-1:0]  result,
  input logic             ovf,
  input logic             illegal
);

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_ok |-> (!res_valid && result == '0 && !ovf && !illegal));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_ok)
    op_valid |=> res_valid);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    !op_valid |=> (!res_valid && $stable(result) && $stable(ovf) && $stable(illegal)));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && ((opcode == OPC_REG && (funct == FN_ADDU || funct == FN_SUBU)) ||
                  opcode == OPC_ADDIU)) |=> !ovf);

  a_r4_nor: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && opcode == OPC_REG && funct == FN_NOR)
      |=> (result == ~($past(src_a) | $past(src_b))));

  a_r6_single_bit: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && (opcode == OPC_SLTI || opcode == OPC_SLTIU ||
                  (opcode == OPC_REG && (funct == FN_SLT || funct == FN_SLTU))))
      |=> (result[XLEN-1:1] == '0));

  a_r7_upper: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && opcode == OPC_LUI)
      |=> (result == {$past(imm16), {(XLEN-IMM_W){1'b0}}}));

  a_r8_zero_shift: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && opcode == OPC_REG && funct == FN_SLL && shamt == '0)
      |=> (result == $past(src_b)));

  a_r9_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_ok)
    illegal |-> (result == '0 && !ovf));

  a_r9_undefined_opcode: assert property (@(posedge clk) disable iff (!rst_ok)
    (op_valid && opcode == 6'o20) |=> illegal);

endmodule

bind ialu_core ialu_core_chk #(.XLEN(XLEN), .IMM_W(IMM_W)) u_chk (
  .clk(clk), .rst_ok(rst_sync_n), .op_valid(op_valid), .opcode(opcode),
  .funct(funct), .src_a(src_a), .src_b(src_b), .imm16(imm16), .shamt(shamt),
  .res_valid(res_valid), .result(result), .ovf(ovf), .illegal(illegal)
);

// File: tb/ialu_core_bench.sv
`timescale 1ns/1ps
module ialu_core_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [5:0]  opcode, funct;
  logic [31:0] src_a, src_b;
  logic [15:0] imm16;
  logic [4:0]  shamt;
  logic        res_valid, ovf, illegal;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [33:0] q_exp [$];
  string       q_tag [$];
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #10 clk = ~clk;

  ialu_core u_ialu_core (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .funct(funct), .src_a(src_a), .src_b(src_b), .imm16(imm16),
    .shamt(shamt), .res_valid(res_valid), .result(result), .ovf(ovf),
    .illegal(illegal)
  );

  function automatic logic [31:0] rnd();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return lfsr ^ {lfsr[15:0], lfsr[31:16]};
  endfunction

  // reference model from the requirements: {illegal, ovf, result}
  function automatic logic [33:0] model(logic [5:0] op, logic [5:0] fn,
      logic [31:0] a, logic [31:0] b, logic [15:0] im, logic [4:0] sh);
    logic [31:0] se, ze, r;
    logic v, bad;
    se = {{16{im[15]}}, im};
    ze = {16'h0, im};
    r = 32'h0; v = 1'b0; bad = 1'b0;
    case (op)
      6'o00: case (fn)
        6'o00: r = b << sh;
        6'o02: r = b >> sh;
        6'o03: r = $unsigned($signed(b) >>> sh);
        6'o40: begin r = a + b; v = (a[31] == b[31]) && (r[31] != a[31]); end
        6'o41: r = a + b;
        6'o42: begin r = a - b; v = (a[31] != b[31]) && (r[31] != a[31]); end
        6'o43: r = a - b;
        6'o44: r = a & b;
        6'o45: r = a | b;
        6'o46: r = a ^ b;
        6'o47: r = ~(a | b);
        6'o52: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        6'o53: r = (a < b) ? 32'd1 : 32'd0;
        default: bad = 1'b1;
      endcase
      6'o10: begin r = a + se; v = (a[31] == se[31]) && (r[31] != a[31]); end
      6'o11: r = a + se;
      6'o12: r = ($signed(a) < $signed(se)) ? 32'd1 : 32'd0;
      6'o13: r = (a < se) ? 32'd1 : 32'd0;
      6'o14: r = a & ze;
      6'o15: r = a | ze;
      6'o16: r = a ^ ze;
      6'o17: r = {im, 16'h0};
      default: bad = 1'b1;
    endcase
    if (bad) begin r = 32'h0; v = 1'b0; end
    return {bad, v, r};
  endfunction

  task automatic check(string tag, logic [33:0] act, logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual ill=%0b ovf=%0b res=%08h expected ill=%0b ovf=%0b res=%08h",
               tag, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic send(logic [5:0] op, logic [5:0] fn, logic [31:0] a,
                      logic [31:0] b, logic [15:0] im, logic [4:0] sh, string tag);
    @(negedge clk);
    op_valid = 1'b1; opcode = op; funct = fn;
    src_a = a; src_b = b; imm16 = im; shamt = sh;
    q_exp.push_back(model(op, fn, a, b, im, sh));
    q_tag.push_back(tag);
  endtask

  // idle cycles carry random data that must be ignored (R2)
  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_valid = 1'b0;
      opcode = rnd()[5:0]; funct = rnd()[5:0];
      src_a = rnd(); src_b = rnd(); imm16 = rnd()[15:0]; shamt = rnd()[4:0];
    end
  endtask

  // monitor / scoreboard
  logic [33:0] last_out;
  bit          seen = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (res_valid) begin
        if (q_exp.size() == 0) begin
          check("R2 unexpected result", {illegal, ovf, result}, 34'h0);
          checks--; errors++; checks++;
        end else begin
          check(q_tag.pop_front(), {illegal, ovf, result}, q_exp.pop_front());
        end
        last_out = {illegal, ovf, result};
        seen = 1;
      end else if (seen) begin
        check("R2 hold on idle", {illegal, ovf, result}, last_out);
      end
    end
  end

  task automatic summary();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: actual run still busy, expected completion");
    summary();
  end

  function automatic void pick(int k, output logic [5:0] op, output logic [5:0] fn);
    op = 6'o00; fn = 6'o40;
    case (k % 21)
      0: fn = 6'o40;  1: fn = 6'o41;  2: fn = 6'o42;  3: fn = 6'o43;
      4: fn = 6'o44;  5: fn = 6'o45;  6: fn = 6'o46;  7: fn = 6'o47;
      8: fn = 6'o52;  9: fn = 6'o53;  10: fn = 6'o00; 11: fn = 6'o02;
      12: fn = 6'o03; 13: op = 6'o10; 14: op = 6'o11; 15: op = 6'o12;
      16: op = 6'o13; 17: op = 6'o14; 18: op = 6'o15; 19: op = 6'o16;
      default: op = 6'o17;
    endcase
  endfunction

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; opcode = '0; funct = '0;
    src_a = '0; src_b = '0; imm16 = '0; shamt = '0;
    repeat (3) @(negedge clk);
    check("R1 reset state", {res_valid, illegal, ovf, result[30:0]}, 34'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", {res_valid, illegal, ovf, result[30:0]}, 34'h0);

    // R3 add/sub family
    send(6'o00, 6'o40, 32'd5, 32'd7, 16'h0, 5'd0, "R3 ADD");
    send(6'o00, 6'o40, 32'h7FFF_FFFF, 32'd1, 16'h0, 5'd0, "R3 ADD overflow");
    send(6'o00, 6'o41, 32'h7FFF_FFFF, 32'd1, 16'h0, 5'd0, "R3 ADDU no flag");
    send(6'o00, 6'o42, 32'd0, 32'd1, 16'h0, 5'd0, "R3 SUB wrap");
    send(6'o00, 6'o42, 32'h8000_0000, 32'd1, 16'h0, 5'd0, "R3 SUB overflow");
    send(6'o00, 6'o43, 32'h8000_0000, 32'd1, 16'h0, 5'd0, "R3 SUBU no flag");
    send(6'o10, 6'o00, 32'h7FFF_FFF0, 32'd0, 16'h0010, 5'd0, "R3 ADDI overflow");
    send(6'o11, 6'o00, 32'h7FFF_FFF0, 32'd0, 16'h0010, 5'd0, "R3 ADDIU no flag");
    // R4 logic
    send(6'o00, 6'o44, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 5'd0, "R4 AND");
    send(6'o00, 6'o45, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 5'd0, "R4 OR");
    send(6'o00, 6'o46, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 5'd0, "R4 XOR");
    send(6'o00, 6'o47, 32'hF0F0_1234, 32'h0FF0_FF00, 16'h0, 5'd0, "R4 NOR");
    // R5 immediate extension
    send(6'o10, 6'o00, 32'd10, 32'd0, 16'hFFFF, 5'd0, "R5 ADDI sign-extend");
    send(6'o14, 6'o00, 32'hFFFF_FFFF, 32'd0, 16'h8001, 5'd0, "R5 ANDI zero-extend");
    send(6'o15, 6'o00, 32'h1234_0000, 32'd0, 16'hFFFF, 5'd0, "R5 ORI zero-extend");
    send(6'o16, 6'o00, 32'hFFFF_FFFF, 32'd0, 16'h8000, 5'd0, "R5 XORI zero-extend");
    // R6 compares
    send(6'o00, 6'o52, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0, "R6 SLT signed true");
    send(6'o00, 6'o53, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0, "R6 SLTU unsigned false");
    send(6'o00, 6'o52, 32'd3, 32'd3, 16'h0, 5'd0, "R6 SLT equal");
    send(6'o12, 6'o00, 32'hFFFF_FFFE, 32'd0, 16'hFFFF, 5'd0, "R6 SLTI");
    send(6'o13, 6'o00, 32'h0000_0005, 32'd0, 16'hFFFF, 5'd0, "R6 SLTIU");
    // R7 upper immediate
    send(6'o17, 6'o00, 32'hDEAD_BEEF, 32'hCAFE_F00D, 16'h0005, 5'd0, "R7 LUI");
    // R8 shifts
    send(6'o00, 6'o00, 32'd0, 32'h8000_0001, 16'h0, 5'd0, "R8 SLL by 0");
    send(6'o00, 6'o00, 32'd0, 32'h0000_0003, 16'h0, 5'd31, "R8 SLL by 31");
    send(6'o00, 6'o02, 32'd0, 32'h8000_0000, 16'h0, 5'd31, "R8 SRL zero fill");
    send(6'o00, 6'o03, 32'd0, 32'h8000_0000, 16'h0, 5'd31, "R8 SRA sign fill");
    send(6'o00, 6'o03, 32'd0, 32'h7000_0000, 16'h0, 5'd4, "R8 SRA positive");
    // R9 undefined
    send(6'o20, 6'o40, 32'd1, 32'd1, 16'h1, 5'd0, "R9 bad opcode");
    send(6'o00, 6'o01, 32'd1, 32'd1, 16'h1, 5'd0, "R9 bad funct 01");
    send(6'o00, 6'o50, 32'd1, 32'd1, 16'h1, 5'd0, "R9 bad funct 50");
    // R2 gaps
    idle(3);
    send(6'o00, 6'o40, 32'd1, 32'd2, 16'h0, 5'd0, "R2 after gap");
    idle(2);
    // mixed random operations
    for (int k = 0; k < 300; k++) begin
      logic [5:0] op, fn;
      pick(k + int'(rnd()[3:0]), op, fn);
      send(op, fn, rnd(), rnd(), rnd()[15:0], rnd()[4:0], "R3 R4 R5 R6 R7 R8 mixed");
      if (rnd()[2:0] == 3'd0) idle(1);
    end
    idle(4);
    checks++;
    if (q_exp.size() != 0) begin
      errors++;
      $display("FAIL R2 results missing: actual %0d pending, expected 0", q_exp.size());
    end
    summary();
  end

endmodule